// File: doc/BRIEF.md
# LED Wall Row-Scan Controller

This block drives a tiled dot-matrix LED wall that is refreshed one row at a time. There are eight scan lines. For the row being served, the controller reads one font byte per tile from a frame memory with a synchronous read port. It hands each byte to the column-latch bus together with the index of the tile that should capture it. Only after the byte for the last tile is on its latch does it switch the shared row latch to that row. It keeps the row lit for a configured number of cycles, blanks it, and then moves on to the next row. After eight rows it starts a new frame.

The frame memory is organised so that the row number picks a 256-byte page and the tile number picks the byte inside it. The font byte for tile `t` on row `r` therefore sits at `r*256 + t`, and a full frame covers addresses 0x000 to 0x7FF.

The tile count and the hold time are taken from configuration inputs at frame boundaries only. A one-cycle frame pulse marks the first read of row 0, so the surrounding logic can swap frame buffers between frames. The hold time is capped at a limit derived from the clock rate. That cap keeps every row refreshed at more than 50 Hz even with the largest tile count.

Top module: `ledwall_scan_ctrl`

## Requirements
- R1: During reset, and in the first cycle after reset is released, `row_drive`, `col_load`, `mem_rd_en` and `frame_start` are all 0.
- R2: In each row period the controller issues exactly N reads, one per cycle, at addresses `row*256 + t` for t = 0 .. N-1 in ascending order. N is the tile count in effect.
- R3: Each read is followed one cycle later by `col_load` = 1, with `col_sel` = the tile index and `col_data` = the byte the memory returned for that read.
- R4: In the cycle after the last `col_load` of a row, `row_drive` becomes one-hot with bit `row` set. It stays so for exactly H cycles, where H is the hold count in effect.
- R5: `row_drive` is all zeros whenever `col_load` is 1. There is at least one all-zero cycle between two lit rows. Rows are served in the order 0, 1, ..., 7 and then back to 0.
- R6: `frame_start` is a single-cycle pulse that coincides with the first read of row 0, at address 0.
- R7: `cfg_tiles` and `cfg_hold` are captured once per frame, in the cycle just before that frame's first read. A change made while a frame is in progress first affects the next frame.
- R8: A `cfg_tiles` value of 0 is treated as 1, and a value above MAX_TILES (default 240) is treated as MAX_TILES.
- R9: A `cfg_hold` value of 0 is treated as 1. Values above a limit derived from CLK_HZ, MIN_REFRESH_HZ and MAX_TILES are cut to that limit, so that eight row periods always fit within one refresh interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tiles | input | PAGE_W (8) | Requested tile count, captured at frame start |
| cfg_hold | input | HOLD_W (20) | Requested row hold time in cycles, captured at frame start |
| mem_rd_en | output | 1 | Frame memory read request |
| mem_rd_addr | output | ROW_W+PAGE_W (11) | Frame memory address {row, tile} |
| mem_rd_data | input | DATA_W (8) | Frame memory read data, valid one cycle after the request |
| col_load | output | 1 | Column latch load strobe |
| col_sel | output | PAGE_W (8) | Index of the tile whose column latch loads |
| col_data | output | DATA_W (8) | Column byte for the selected tile |
| row_drive | output | ROWS (8) | Row latch pattern, one-hot when lit and all zeros when blanked |
| frame_start | output | 1 | One-cycle pulse at the first read of row 0 |

## Verification
The hardest case to reach from the ports is a configuration change made while a frame is in progress. It must leave the current frame untouched and take effect in the next one. The bench waits for each `frame_start` pulse and changes both configuration inputs in that same cycle. At that moment it queues the whole token stream of the next frame, built from the new values, behind the stream of the frame still running. Any early or late capture then shows up as a wrong tile count or a wrong lit length. The sequence of configurations also passes through tile counts 0 and 250 and a hold of 0, which exercises the clamping at both ends.

// File: rtl/ledwall_scan_pkg.sv
// Package: shared types for the LED wall row-scan controller.
// Assumes: sequencer states are one-hot-free binary encoded.
package ledwall_scan_pkg;

    typedef enum logic [2:0] {
        SCN_START = 3'd0,   // capture configuration for a new frame
        SCN_LOAD  = 3'd1,   // issue one frame-memory read per tile
        SCN_DRAIN = 3'd2,   // last read returns, last column load
        SCN_LIT   = 3'd3,   // row enabled for the hold time
        SCN_BLANK = 3'd4    // row blanked before the next one
    } scan_state_t;

endpackage

// File: rtl/ledwall_cfg_shadow.sv
// Module: ledwall_cfg_shadow
// Clamps the tile count and the hold time and holds them stable for one frame.
// Assumes: capture is high for exactly one cycle per frame, before the first read.
module ledwall_cfg_shadow #(
    parameter int PAGE_W    = 8,
    parameter int HOLD_W    = 20,
    parameter int MAX_TILES = 240,
    parameter int HOLD_MAX  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [PAGE_W-1:0] cfg_tiles,
    input  logic [HOLD_W-1:0] cfg_hold,
    output logic [PAGE_W-1:0] tiles_q,
    output logic [HOLD_W-1:0] hold_q
);

    logic [PAGE_W-1:0] tiles_clamped;
    logic [HOLD_W-1:0] hold_clamped;

    // Clamp the requested tile count into 1 .. MAX_TILES.
    always_comb begin
        if (cfg_tiles == '0)
            tiles_clamped = PAGE_W'(1);
        else if (int'(cfg_tiles) > MAX_TILES)
            tiles_clamped = PAGE_W'(MAX_TILES);
        else
            tiles_clamped = cfg_tiles;
    end

    // Clamp the requested hold time into 1 .. HOLD_MAX.
    always_comb begin
        if (cfg_hold == '0)
            hold_clamped = HOLD_W'(1);
        else if (int'(cfg_hold) > HOLD_MAX)
            hold_clamped = HOLD_W'(HOLD_MAX);
        else
            hold_clamped = cfg_hold;
    end

    // Capture the clamped values at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tiles_q <= PAGE_W'(1);
            hold_q  <= HOLD_W'(1);
        end else if (capture) begin
            tiles_q <= tiles_clamped;
            hold_q  <= hold_clamped;
        end
    end

    AST_TILES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tiles_q != '0) && (int'(tiles_q) <= MAX_TILES)); // R8

    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) && (int'(hold_q) <= HOLD_MAX)); // R9

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> ($stable(tiles_q) && $stable(hold_q))); // R7

endmodule

// File: rtl/ledwall_scan_seq.sv
// Module: ledwall_scan_seq
// Steps through frame start, tile loading, row hold and blanking for each row.
// Assumes: tiles and hold come from ledwall_cfg_shadow and are at least 1.
module ledwall_scan_seq
    import ledwall_scan_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int PAGE_W = 8,
    parameter int HOLD_W = 20,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       tiles,
    input  logic [HOLD_W-1:0]       hold,
    output logic                    capture,
    output logic                    rd_en,
    output logic [ROW_W+PAGE_W-1:0] rd_addr,
    output logic [PAGE_W-1:0]       rd_tile,
    output logic [ROW_W-1:0]        row,
    output logic                    lit,
    output logic                    frame_start
);

    scan_state_t       state_q, state_d;
    logic [ROW_W-1:0]  row_q, row_d;
    logic [PAGE_W-1:0] tile_q, tile_d;
    logic [HOLD_W-1:0] hold_cnt_q, hold_cnt_d;
    logic              last_tile;
    logic              last_row;
    logic              hold_done;

    assign last_tile = (tile_q == tiles - PAGE_W'(1));
    assign last_row  = (row_q == ROW_W'(ROWS - 1));
    assign hold_done = (hold_cnt_q == hold);

    // Next-state and counter update for the scan sequence.
    always_comb begin
        state_d    = state_q;
        row_d      = row_q;
        tile_d     = tile_q;
        hold_cnt_d = hold_cnt_q;
        unique case (state_q)
            SCN_START: begin
                row_d   = '0;
                tile_d  = '0;
                state_d = SCN_LOAD;
            end
            SCN_LOAD: begin
                if (last_tile) begin
                    tile_d  = '0;
                    state_d = SCN_DRAIN;
                end else begin
                    tile_d = tile_q + PAGE_W'(1);
                end
            end
            SCN_DRAIN: begin
                hold_cnt_d = HOLD_W'(1);
                state_d    = SCN_LIT;
            end
            SCN_LIT: begin
                if (hold_done)
                    state_d = SCN_BLANK;
                else
                    hold_cnt_d = hold_cnt_q + HOLD_W'(1);
            end
            SCN_BLANK: begin
                if (last_row) begin
                    state_d = SCN_START;
                end else begin
                    row_d   = row_q + ROW_W'(1);
                    state_d = SCN_LOAD;
                end
            end
            default: state_d = SCN_START;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SCN_START;
            row_q      <= '0;
            tile_q     <= '0;
            hold_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            row_q      <= row_d;
            tile_q     <= tile_d;
            hold_cnt_q <= hold_cnt_d;
        end
    end

    // Decode the current state into the outputs.
    always_comb begin
        capture     = (state_q == SCN_START);
        rd_en       = (state_q == SCN_LOAD);
        rd_addr     = {row_q, tile_q};
        rd_tile     = tile_q;
        row         = row_q;
        lit         = (state_q == SCN_LIT);
        frame_start = (state_q == SCN_LOAD) && (row_q == '0) && (tile_q == '0);
    end

    AST_READ_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[PAGE_W-1:0] < tiles)); // R2

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        lit |-> (hold_cnt_q <= hold)); // R4

    AST_FRAME_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (rd_en && rd_addr == '0 && $past(capture))); // R6

endmodule

// File: rtl/ledwall_col_pipe.sv
// Module: ledwall_col_pipe
// Aligns the column-latch strobe and tile index with the memory's read data.
// Assumes: the frame memory returns data exactly one cycle after a read.
module ledwall_col_pipe #(
    parameter int PAGE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [PAGE_W-1:0] rd_tile,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              col_load,
    output logic [PAGE_W-1:0] col_sel,
    output logic [DATA_W-1:0] col_data
);

    logic              load_q;
    logic [PAGE_W-1:0] sel_q;

    // Delay the read strobe and tile index by the memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            load_q <= rd_en;
            sel_q  <= rd_tile;
        end
    end

    // Present memory data only while a load is active.
    always_comb begin
        col_load = load_q;
        col_sel  = sel_q;
        col_data = load_q ? mem_rd_data : '0;
    end

    AST_SEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && !$past(col_load)) |-> (col_sel == '0)); // R2

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && $past(col_load)) |-> (col_sel == $past(col_sel) + PAGE_W'(1))); // R3

    AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> col_load); // R3

endmodule

// File: rtl/ledwall_row_drv.sv
// Module: ledwall_row_drv
// Decodes the active row into the one-hot row latch pattern.
// Assumes: lit is high only during the hold window of a row.
module ledwall_row_drv #(
    parameter int ROWS  = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lit,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  row_drive
);

    // One decoder bit per scan line.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign row_drive[i] = lit && (row == ROW_W'(i));
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_drive)); // R5

    AST_ROW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_drive != '0) && ($past(row_drive) != '0)) |-> (row_drive == $past(row_drive))); // R5

endmodule

// File: rtl/ledwall_scan_ctrl.sv
// Module: ledwall_scan_ctrl (top)
// Row-scan controller for a tiled LED wall: loads all column latches of a row
// from frame memory, then lights that row for a held time, then blanks it.
// Assumes: frame memory has a one-cycle synchronous read, and the byte for
// tile t, row r sits at address r*256 + t.
module ledwall_scan_ctrl #(
    parameter int ROWS           = 8,
    parameter int PAGE_W         = 8,
    parameter int DATA_W         = 8,
    parameter int HOLD_W         = 20,
    parameter int MAX_TILES      = 240,
    parameter int CLK_HZ         = 250_000_000,
    parameter int MIN_REFRESH_HZ = 51,
    localparam int ROW_W         = $clog2(ROWS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       cfg_tiles,
    input  logic [HOLD_W-1:0]       cfg_hold,
    output logic                    mem_rd_en,
    output logic [ROW_W+PAGE_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0]       mem_rd_data,
    output logic                    col_load,
    output logic [PAGE_W-1:0]       col_sel,
    output logic [DATA_W-1:0]       col_data,
    output logic [ROWS-1:0]         row_drive,
    output logic                    frame_start
);

    // Cycles one row may take so that a full frame meets the refresh minimum.
    localparam int ROW_BUDGET = CLK_HZ / MIN_REFRESH_HZ / ROWS;
    // Per row: tiles + drain + blank, plus the frame-start cycle counted per row.
    localparam int HOLD_MAX   = ROW_BUDGET - MAX_TILES - 3;

    logic [PAGE_W-1:0] tiles_q;
    logic [HOLD_W-1:0] hold_q;
    logic              capture;
    logic [PAGE_W-1:0] rd_tile;
    logic [ROW_W-1:0]  row;
    logic              lit;

    ledwall_cfg_shadow #(
        .PAGE_W    (PAGE_W),
        .HOLD_W    (HOLD_W),
        .MAX_TILES (MAX_TILES),
        .HOLD_MAX  (HOLD_MAX)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .cfg_tiles (cfg_tiles),
        .cfg_hold  (cfg_hold),
        .tiles_q   (tiles_q),
        .hold_q    (hold_q)
    );

    ledwall_scan_seq #(
        .ROWS   (ROWS),
        .PAGE_W (PAGE_W),
        .HOLD_W (HOLD_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tiles       (tiles_q),
        .hold        (hold_q),
        .capture     (capture),
        .rd_en       (mem_rd_en),
        .rd_addr     (mem_rd_addr),
        .rd_tile     (rd_tile),
        .row         (row),
        .lit         (lit),
        .frame_start (frame_start)
    );

    ledwall_col_pipe #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) col_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (mem_rd_en),
        .rd_tile     (rd_tile),
        .mem_rd_data (mem_rd_data),
        .col_load    (col_load),
        .col_sel     (col_sel),
        .col_data    (col_data)
    );

    ledwall_row_drv #(
        .ROWS (ROWS)
    ) row_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lit       (lit),
        .row       (row),
        .row_drive (row_drive)
    );

    AST_DARK_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        col_load |-> (row_drive == '0)); // R5

    AST_LIGHT_AFTER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(row_drive != '0)) |-> $past(col_load)); // R4

endmodule

// File: tb/ledwall_scan_ctrl_tb_top.sv
// Scoreboard bench: a driver queues the expected token stream of each frame,
// a monitor turns the outputs into tokens and compares them in order.
module ledwall_scan_ctrl_tb_top;

    localparam int ROWS   = 8;
    localparam int PAGE_W = 8;
    localparam int DATA_W = 8;
    localparam int HOLD_W = 20;

    localparam int K_FRAME = 0;
    localparam int K_LOAD  = 1;
    localparam int K_LIT   = 2;

    typedef struct {
        int    kind;
        int    a;
        int    b;
        string tag;
    } tok_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PAGE_W-1:0] cfg_tiles = '0;
    logic [HOLD_W-1:0] cfg_hold = '0;
    logic              mem_rd_en;
    logic [10:0]       mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              col_load;
    logic [PAGE_W-1:0] col_sel;
    logic [DATA_W-1:0] col_data;
    logic [ROWS-1:0]   row_drive;
    logic              frame_start;

    int   n_checks = 0;
    int   n_fail   = 0;
    tok_t exp_q[$];
    bit   mon_done = 1'b0;
    int   cycles   = 0;

    always #2 clk = ~clk;

    ledwall_scan_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_tiles   (cfg_tiles),
        .cfg_hold    (cfg_hold),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .col_load    (col_load),
        .col_sel     (col_sel),
        .col_data    (col_data),
        .row_drive   (row_drive),
        .frame_start (frame_start)
    );

    function automatic logic [7:0] font_byte(int r, int t);
        return 8'(t) ^ 8'(r * 37);
    endfunction

    // Frame memory model with one-cycle synchronous read.
    always @(posedge clk) begin
        if (mem_rd_en)
            mem_rd_data <= font_byte(int'(mem_rd_addr[10:8]), int'(mem_rd_addr[7:0]));
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(int kind, int a, int b, string tag);
        tok_t t;
        t.kind = kind; t.a = a; t.b = b; t.tag = tag;
        exp_q.push_back(t);
    endtask

    // Driver: queue the whole expected token stream of one frame.
    task automatic push_frame(int nt, int nh, string tg);
        push(K_FRAME, 0, 0, {"R6 ", tg});
        for (int r = 0; r < ROWS; r++) begin
            for (int t = 0; t < nt; t++)
                push(K_LOAD, t, int'(font_byte(r, t)), {"R2 R3 ", tg});
            push(K_LIT, 1 << r, nh, {"R4 R5 ", tg});
        end
    endtask

    task automatic consume(int kind, int a, int b);
        tok_t e;
        if (mon_done) return;
        if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected token", kind, -1);
            return;
        end
        e = exp_q.pop_front();
        check(e.kind == kind, {e.tag, " kind"}, kind, e.kind);
        check(e.a == a, {e.tag, " field a"}, a, e.a);
        check(e.b == b, {e.tag, " field b"}, b, e.b);
        if (exp_q.size() == 0) mon_done = 1'b1;
    endtask

    // Monitor: sample away from the active edge and compare tokens in order.
    int            post_rst = 0;
    logic [ROWS-1:0] prev_drive = '0;
    int            lit_len = 0;
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            check(row_drive == '0 && !col_load && !mem_rd_en && !frame_start,
                  "R1 reset outputs", int'(row_drive), 0);
        end else begin
            if (post_rst == 0)
                check(row_drive == '0 && !col_load && !mem_rd_en && !frame_start,
                      "R1 first cycle after reset", int'(mem_rd_en), 0);
            post_rst++;
            if (col_load && row_drive != '0)
                check(1'b0, "R5 load while lit", int'(row_drive), 0);
            if (row_drive != '0 && prev_drive != '0 && row_drive != prev_drive)
                check(1'b0, "R5 no blank between rows", int'(row_drive), 0);
            if (frame_start) consume(K_FRAME, 0, 0);
            if (col_load) consume(K_LOAD, int'(col_sel), int'(col_data));
            if (row_drive != '0) begin
                lit_len = (prev_drive == '0) ? 1 : lit_len + 1;
            end else if (prev_drive != '0) begin
                consume(K_LIT, int'(prev_drive), lit_len);
            end
            prev_drive = row_drive;
        end
    end

    // Stimulus: each configuration change lands mid-frame, at a frame pulse.
    initial begin
        cfg_tiles = 8'd3;
        cfg_hold  = 20'd4;
        push_frame(3, 4, "base");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        @(negedge clk iff frame_start);
        cfg_tiles = 8'd0; cfg_hold = 20'd0;          // R8 R9 low clamps
        push_frame(1, 1, "R7 R8 R9 zero clamp");

        @(negedge clk iff frame_start);
        cfg_tiles = 8'd250; cfg_hold = 20'd2;        // R8 high clamp
        push_frame(240, 2, "R7 R8 max tiles");

        @(negedge clk iff frame_start);
        cfg_tiles = 8'd5; cfg_hold = 20'd10;
        push_frame(5, 10, "R7 mid-frame change");

        @(negedge clk iff frame_start);
        cfg_tiles = 8'd1; cfg_hold = 20'd3;
        push_frame(1, 3, "R7 single tile");

        while (!mon_done && cycles < 100000) @(negedge clk);
        if (!mon_done) check(1'b0, "watchdog expired", cycles, 100000);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule